// File: doc/BRIEF.md
# Speculative Poison Register File

This block is a register file in which every entry carries a poison flag beside its data. The flag marks a value that a speculative instruction could not compute because that instruction would have faulted. An instruction hoisted above a branch writes through the write port with its speculative and fault flags. A speculative write that faults stores poison instead of trapping. Any later write that uses a poisoned source register passes the poison on to its own destination.

A non-speculative write that faults traps at once on `exc_now`. It leaves its destination register untouched and creates no poison. When the program reaches the original position of the hoisted instruction, a check operation tests one register. The block raises a deferred exception, together with that register's index, only if the register holds poison.

The recovery code, the instruction execution and the pipeline are outside this block. This block keeps the state and applies the rules for generating, propagating and testing poison.

Top module: `prf_nat_regfile`

## Requirements
- R1: After reset every register reads data 0 with its poison flag clear, and `chk_exc` is low.
- R2: A write with `wr_spec`=1 and `wr_fault`=1 stores `wr_data` with the poison flag set and leaves `exc_now` low.
- R3: The poison flag written by a non-trapping write is set when any source slot whose `wr_src_use` bit is 1 names a poisoned register. Slot k uses index bits `wr_src_idx[k*IDX_W +: IDX_W]`. A slot whose use bit is 0 has no effect.
- R4: A write with `wr_fault`=1 and `wr_spec`=0 drives `exc_now` high in the same cycle and leaves both the data and the poison flag of its destination unchanged.
- R5: A write that does not fault and has no poisoned used source stores `wr_data` and clears the destination's poison flag.
- R6: One cycle after a check with `chk_en`=1, `chk_exc` equals the checked register's poison flag. When `chk_en`=1, `chk_exc_idx` takes the checked index. While `chk_en`=0, `chk_exc` is 0 one cycle later and `chk_exc_idx` holds its value.
- R7: A read port reads combinationally. Read port p uses `rd_idx[p*IDX_W +: IDX_W]`, `rd_data[p*DATA_W +: DATA_W]` and `rd_poison[p]`. When that port reads the register being written in the same cycle, it returns the new data and the new poison flag.
- R8: A check of the register being written in the same cycle sees the new poison flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write request |
| wr_idx | input | IDX_W | Destination register |
| wr_data | input | DATA_W | Write data |
| wr_spec | input | 1 | Writer is a speculative (hoisted) instruction |
| wr_fault | input | 1 | Writer hit a fault |
| wr_src_idx | input | NUM_SRC*IDX_W | Source register of each source slot |
| wr_src_use | input | NUM_SRC | Source slot is in use |
| rd_idx | input | NUM_RD*IDX_W | Read addresses |
| rd_data | output | NUM_RD*DATA_W | Read data |
| rd_poison | output | NUM_RD | Poison flag of each read |
| chk_en | input | 1 | Check request |
| chk_idx | input | IDX_W | Register to check |
| chk_exc | output | 1 | Deferred exception, one cycle after the check |
| chk_exc_idx | output | IDX_W | Index of the most recently checked register |
| exc_now | output | 1 | Immediate exception from a non-speculative fault |

## Verification
The bench builds the block with its defaults: 16 registers, 32-bit data, two read ports, two source slots and the write-first variant. With only 16 registers, random indices often line up. Writes land on registers that the same cycle's read and check operations address. Source slots point at freshly poisoned entries, so poison chains several writes deep form quickly. These conditions make the bypass paths for R7 and R8 and the propagation rule of R3 common events instead of rare ones.

// File: rtl/prf_pkg.sv
package prf_pkg;
   typedef enum logic [1:0] {
      WK_IDLE   = 2'd0,
      WK_COMMIT = 2'd1,
      WK_TRAP   = 2'd2
   } wr_kind_e;

   function automatic wr_kind_e classify(input logic en, input logic spec, input logic fault);
      if (!en)                return WK_IDLE;
      else if (fault && !spec) return WK_TRAP;
      else                    return WK_COMMIT;
   endfunction
endpackage

// File: rtl/prf_poison_calc.sv
module prf_poison_calc #(
   parameter int NUM_REGS = 16,
   parameter int NUM_SRC  = 2,
   parameter int IDX_W    = 4
) (
   input  logic [NUM_REGS-1:0]      poison_vec,
   input  logic [NUM_SRC*IDX_W-1:0] src_idx,
   input  logic [NUM_SRC-1:0]       src_use,
   input  logic                     spec,
   input  logic                     fault,
   output logic                     poison_out
);
   logic [NUM_SRC-1:0] src_hit;

   generate
      for (genvar g = 0; g < NUM_SRC; g++) begin : g_src
         assign src_hit[g] = src_use[g] & poison_vec[src_idx[g*IDX_W +: IDX_W]];
      end
   endgenerate

   // own deferred fault, or inherited from any used source
   assign poison_out = (spec & fault) | (|src_hit);
endmodule

// File: rtl/prf_read_port.sv
module prf_read_port #(
   parameter int NUM_REGS    = 16,
   parameter int DATA_W      = 32,
   parameter int IDX_W       = 4,
   parameter bit WRITE_FIRST = 1'b1
) (
   input  logic [DATA_W-1:0]   regs [NUM_REGS],
   input  logic [NUM_REGS-1:0] poison_vec,
   input  logic [IDX_W-1:0]    rd_idx,
   input  logic                byp_en,
   input  logic [IDX_W-1:0]    byp_idx,
   input  logic [DATA_W-1:0]   byp_data,
   input  logic                byp_poison,
   output logic [DATA_W-1:0]   rd_data,
   output logic                rd_poison
);
   generate
      if (WRITE_FIRST) begin : g_write_first
         always_comb begin
            if (byp_en && (byp_idx == rd_idx)) begin
               rd_data   = byp_data;
               rd_poison = byp_poison;
            end else begin
               rd_data   = regs[rd_idx];
               rd_poison = poison_vec[rd_idx];
            end
         end
      end else begin : g_read_first
         assign rd_data   = regs[rd_idx];
         assign rd_poison = poison_vec[rd_idx];
      end
   endgenerate
endmodule

// File: rtl/prf_check_unit.sv
module prf_check_unit #(
   parameter int NUM_REGS = 16,
   parameter int IDX_W    = 4
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic [NUM_REGS-1:0] poison_vec,
   input  logic                chk_en,
   input  logic [IDX_W-1:0]    chk_idx,
   input  logic                byp_en,
   input  logic [IDX_W-1:0]    byp_idx,
   input  logic                byp_poison,
   output logic                chk_exc,
   output logic [IDX_W-1:0]    chk_exc_idx
);
   logic poison_eff;

   assign poison_eff = (byp_en && (byp_idx == chk_idx)) ? byp_poison : poison_vec[chk_idx];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         chk_exc     <= 1'b0;
         chk_exc_idx <= '0;
      end else begin
         chk_exc <= chk_en & poison_eff;
         if (chk_en) chk_exc_idx <= chk_idx;
      end
   end

   AST_EXC_NEEDS_CHECK: assert property (@(posedge clk) disable iff (!rst_n)
      chk_exc |-> $past(chk_en)) else $error("exception without check"); // R6
   AST_IDX_HOLDS_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      !chk_en |=> $stable(chk_exc_idx)) else $error("index moved while idle"); // R6
endmodule

// File: rtl/prf_nat_regfile.sv
module prf_nat_regfile #(
   parameter int NUM_REGS    = 16,
   parameter int DATA_W      = 32,
   parameter int NUM_RD      = 2,
   parameter int NUM_SRC     = 2,
   parameter bit WRITE_FIRST = 1'b1,
   localparam int IDX_W      = $clog2(NUM_REGS)
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     wr_en,
   input  logic [IDX_W-1:0]         wr_idx,
   input  logic [DATA_W-1:0]        wr_data,
   input  logic                     wr_spec,
   input  logic                     wr_fault,
   input  logic [NUM_SRC*IDX_W-1:0] wr_src_idx,
   input  logic [NUM_SRC-1:0]       wr_src_use,
   input  logic [NUM_RD*IDX_W-1:0]  rd_idx,
   output logic [NUM_RD*DATA_W-1:0] rd_data,
   output logic [NUM_RD-1:0]        rd_poison,
   input  logic                     chk_en,
   input  logic [IDX_W-1:0]         chk_idx,
   output logic                     chk_exc,
   output logic [IDX_W-1:0]         chk_exc_idx,
   output logic                     exc_now
);
   import prf_pkg::*;

   initial begin
      AST_PARAM_REGS: assert (NUM_REGS >= 2 && (1 << IDX_W) == NUM_REGS)
         else $error("NUM_REGS must be a power of two, at least 2"); // R1
      AST_PARAM_PORTS: assert (NUM_RD >= 1 && NUM_SRC >= 1 && DATA_W >= 1)
         else $error("need a read port, a source slot and data bits"); // R7
   end

   logic [DATA_W-1:0]   data_q [NUM_REGS];
   logic [NUM_REGS-1:0] poison_q;
   logic                new_poison;
   logic                commit;
   wr_kind_e            wr_kind;

   assign wr_kind = classify(wr_en, wr_spec, wr_fault);
   assign commit  = (wr_kind == WK_COMMIT);
   assign exc_now = (wr_kind == WK_TRAP);

   prf_poison_calc #(.NUM_REGS(NUM_REGS), .NUM_SRC(NUM_SRC), .IDX_W(IDX_W)) i_calc (
      .poison_vec(poison_q),
      .src_idx   (wr_src_idx),
      .src_use   (wr_src_use),
      .spec      (wr_spec),
      .fault     (wr_fault),
      .poison_out(new_poison)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         poison_q <= '0;
         for (int i = 0; i < NUM_REGS; i++) data_q[i] <= '0;
      end else if (commit) begin
         data_q[wr_idx]   <= wr_data;
         poison_q[wr_idx] <= new_poison;
      end
   end

   generate
      for (genvar p = 0; p < NUM_RD; p++) begin : g_rd
         prf_read_port #(.NUM_REGS(NUM_REGS), .DATA_W(DATA_W), .IDX_W(IDX_W),
                         .WRITE_FIRST(WRITE_FIRST)) i_port (
            .regs      (data_q),
            .poison_vec(poison_q),
            .rd_idx    (rd_idx[p*IDX_W +: IDX_W]),
            .byp_en    (commit),
            .byp_idx   (wr_idx),
            .byp_data  (wr_data),
            .byp_poison(new_poison),
            .rd_data   (rd_data[p*DATA_W +: DATA_W]),
            .rd_poison (rd_poison[p])
         );
      end
   endgenerate

   prf_check_unit #(.NUM_REGS(NUM_REGS), .IDX_W(IDX_W)) i_check (
      .clk        (clk),
      .rst_n      (rst_n),
      .poison_vec (poison_q),
      .chk_en     (chk_en),
      .chk_idx    (chk_idx),
      .byp_en     (commit),
      .byp_idx    (wr_idx),
      .byp_poison (new_poison),
      .chk_exc    (chk_exc),
      .chk_exc_idx(chk_exc_idx)
   );

   AST_SPEC_FAULT_POISONS: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_spec && wr_fault) |=> poison_q[$past(wr_idx)]) else $error("no poison stored"); // R2
   AST_TRAP_KEEPS_STATE: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_fault && !wr_spec) |=> $stable(poison_q)) else $error("trap changed poison"); // R4
   AST_CLEAN_WRITE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      (commit && !new_poison) |=> !poison_q[$past(wr_idx)]) else $error("poison not cleared"); // R5
endmodule

// File: tb/test_prf_nat_regfile.sv
module test_prf_nat_regfile;
   localparam int NR = 16, DW = 32, IW = 4;

   logic clk = 1'b0, rst_n = 1'b0;
   logic wr_en = 0, wr_spec = 0, wr_fault = 0, chk_en = 0;
   logic [IW-1:0] wr_idx = '0, chk_idx = '0, ra0 = '0, ra1 = '0, s0 = '0, s1 = '0;
   logic [DW-1:0] wr_data = '0;
   logic [1:0] wr_src_use = '0;
   logic [2*DW-1:0] rd_data;
   logic [1:0] rd_poison;
   logic chk_exc, exc_now;
   logic [IW-1:0] chk_exc_idx;

   int checks = 0, failures = 0;
   string cur_tag = "R1";
   logic [DW-1:0] ref_data [NR];
   logic [NR-1:0] ref_pois = '0;
   logic exp_chk = 0;
   logic [IW-1:0] exp_chk_idx = '0;
   string chk_tag = "R1";

   always #10 clk = ~clk;

   prf_nat_regfile i_prf_nat_regfile (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data),
      .wr_spec(wr_spec), .wr_fault(wr_fault), .wr_src_idx({s1, s0}), .wr_src_use(wr_src_use),
      .rd_idx({ra1, ra0}), .rd_data(rd_data), .rd_poison(rd_poison),
      .chk_en(chk_en), .chk_idx(chk_idx), .chk_exc(chk_exc), .chk_exc_idx(chk_exc_idx),
      .exc_now(exc_now)
   );

   task automatic check(input string tag, input string what, input logic [DW-1:0] act, input logic [DW-1:0] exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
      end
   endtask

   function automatic logic f_poison(input logic spec, input logic fault);
      logic p = spec & fault;
      if (wr_src_use[0] && ref_pois[s0]) p = 1'b1;
      if (wr_src_use[1] && ref_pois[s1]) p = 1'b1;
      return p;
   endfunction

   // inputs are already driven; checks combinational outputs, updates model, then checks the check port
   task automatic cycle_check();
      logic trap, commit, np;
      logic [IW-1:0] ra [2];
      #1;
      ra[0] = ra0; ra[1] = ra1;
      trap   = wr_en && wr_fault && !wr_spec;
      commit = wr_en && !trap;
      np     = f_poison(wr_spec, wr_fault);
      for (int p = 0; p < 2; p++) begin
         logic hit = commit && (wr_idx == ra[p]);
         check(hit ? "R7" : cur_tag, "rd_data", rd_data[p*DW +: DW], hit ? wr_data : ref_data[ra[p]]);
         check(hit ? "R7" : cur_tag, "rd_poison", {31'b0, rd_poison[p]}, {31'b0, hit ? np : ref_pois[ra[p]]});
      end
      check("R4", "exc_now", {31'b0, exc_now}, {31'b0, trap});
      if (chk_en) begin
         chk_tag     = (commit && wr_idx == chk_idx) ? "R8" : "R6";
         exp_chk     = (commit && wr_idx == chk_idx) ? np : ref_pois[chk_idx];
         exp_chk_idx = chk_idx;
      end else begin
         chk_tag = "R6";
         exp_chk = 1'b0;
      end
      if (commit) begin
         ref_data[wr_idx] = wr_data;
         ref_pois[wr_idx] = np;
      end
      @(negedge clk);
      check(chk_tag, "chk_exc", {31'b0, chk_exc}, {31'b0, exp_chk});
      check(chk_tag, "chk_exc_idx", {28'b0, chk_exc_idx}, {28'b0, exp_chk_idx});
   endtask

   task automatic set_wr(input logic en, input int idx, input logic [DW-1:0] d, input logic sp,
                         input logic fl, input int a, input int b, input logic [1:0] use_m);
      wr_en = en; wr_idx = IW'(idx); wr_data = d; wr_spec = sp; wr_fault = fl;
      s0 = IW'(a); s1 = IW'(b); wr_src_use = use_m;
   endtask

   task automatic set_rc(input int a, input int b, input logic ce, input int ci);
      ra0 = IW'(a); ra1 = IW'(b); chk_en = ce; chk_idx = IW'(ci);
   endtask

   initial begin : watchdog
      repeat (150000) @(posedge clk);
      failures++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      logic [31:0] r;
      for (int i = 0; i < NR; i++) ref_data[i] = '0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      // R1: reset state of every register and of the check port
      check("R1", "chk_exc", {31'b0, chk_exc}, 32'd0);
      cur_tag = "R1";
      for (int i = 0; i < NR; i += 2) begin
         set_wr(0, 0, 0, 0, 0, 0, 0, 2'b00); set_rc(i, i + 1, 0, 0);
         cycle_check();
      end
      // R2: speculative fault poisons r3, no immediate trap
      cur_tag = "R2";
      set_wr(1, 3, 32'hAAAA_0003, 1, 1, 0, 0, 2'b00); set_rc(0, 1, 0, 0); cycle_check();
      set_wr(0, 0, 0, 0, 0, 0, 0, 2'b00); set_rc(3, 3, 0, 0); cycle_check();
      check("R2", "r3 poisoned", {31'b0, rd_poison[0]}, 32'd1);
      // R3: poison propagates through used slot 1, not through an unused slot
      cur_tag = "R3";
      set_wr(1, 5, 32'h5555, 0, 0, 1, 3, 2'b10); set_rc(0, 0, 0, 0); cycle_check();
      set_wr(1, 6, 32'h6666, 0, 0, 3, 3, 2'b00); set_rc(5, 6, 0, 0); cycle_check();
      check("R3", "r5 inherits", {31'b0, rd_poison[0]}, 32'd1);
      check("R3", "r6 unused slot", {31'b0, rd_poison[1]}, 32'd0);
      // R4: non-speculative fault traps and keeps r5 as it was
      cur_tag = "R4";
      set_wr(1, 5, 32'hDEAD, 0, 1, 0, 0, 2'b00); set_rc(5, 5, 0, 0); cycle_check();
      set_wr(0, 0, 0, 0, 0, 0, 0, 2'b00); set_rc(5, 6, 0, 0); cycle_check();
      check("R4", "r5 data kept", rd_data[DW-1:0], 32'h5555);
      // R6: check of poisoned r5, clean r6, disabled check
      set_wr(0, 0, 0, 0, 0, 0, 0, 2'b00); set_rc(0, 0, 1, 5); cycle_check();
      check("R6", "exc on r5", {31'b0, chk_exc}, 32'd1);
      check("R6", "exc idx", {28'b0, chk_exc_idx}, 32'd5);
      set_rc(0, 0, 1, 6); cycle_check();
      set_rc(0, 0, 0, 5); cycle_check();
      // R5: clean write clears poison of r3
      cur_tag = "R5";
      set_wr(1, 3, 32'h3333, 0, 0, 6, 6, 2'b11); set_rc(0, 0, 0, 0); cycle_check();
      set_wr(0, 0, 0, 0, 0, 0, 0, 2'b00); set_rc(3, 0, 0, 0); cycle_check();
      check("R5", "r3 clean", {31'b0, rd_poison[0]}, 32'd0);
      // R7 / R8: same-cycle write, read and check of r9
      set_wr(1, 9, 32'h9999, 1, 1, 0, 0, 2'b00); set_rc(9, 9, 1, 9); cycle_check();
      check("R8", "check sees new poison", {31'b0, chk_exc}, 32'd1);
      set_wr(1, 9, 32'h1234, 0, 0, 0, 0, 2'b00); set_rc(9, 2, 1, 9); cycle_check();
      check("R8", "check sees cleared", {31'b0, chk_exc}, 32'd0);
      // random mix
      cur_tag = "R3";
      r = $urandom(32'h5eed);
      for (int n = 0; n < 2000; n++) begin
         int wi;
         r  = $urandom();
         wi = int'(r[3:0]);
         set_wr(r[4] | r[5], wi, $urandom(), r[6], r[7] & r[8], int'(r[12:9]), int'(r[16:13]), r[18:17]);
         set_rc(r[19] ? wi : int'(r[23:20]), int'(r[27:24]), r[28], r[29] ? wi : int'(r[31:30]));
         cycle_check();
      end
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule